// File: doc/BRIEF.md
# Issue-Time Instruction Access Exception Prioritizer

This block decides, at the moment an instruction issues, which single access exception that instruction raises, if it raises one at all. It compares a small set of instruction attribute flags against the enable bits of the processor status word. It walks a fixed chain of checks, and the first check that applies settles the outcome. The instruction's attributes are a bundle constraint violation, non-excepting, conditional, floating-point, float-register access, media, media-trap and privileged.

The floating-point and media checks behave as gates rather than as plain tests. When one of those units is disabled, its branch of the chain is taken. Every later check is then skipped, even if the instruction turns out to be innocent for that unit, in which case nothing is raised. The verdict is registered, so it appears one clock after the issue strobe as a one-hot code with a valid strobe. A downstream queue or trap sequencer consumes it.

Top module: `issue_excp_prio`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, `excp_vld` is 0 and `excp_code` is all zeros.
- R2: `excp_vld` equals the value `issue_vld` had at the previous rising clock edge. Whenever `excp_vld` is 0, `excp_code` is all zeros.
- R3: If `bundle_viol` is 1, the code is illegal-instruction (`excp_code` bit 0), whatever the other inputs are.
- R4: Otherwise, if the non-excepting attribute (`insn_attr` bit 0) is set while non-excepting mode (`psw_bits` bit 0) is clear, the code is not-implemented (bit 1).
- R5: Otherwise, if the conditional attribute (`insn_attr` bit 1) is set while conditional mode (`psw_bits` bit 1) is clear, the code is not-implemented (bit 1).
- R6: Otherwise, if float enable (`psw_bits` bit 2) is clear, the code is float-disabled (bit 2) exactly when the float attribute (`insn_attr` bit 2) is set, or when float-register access (`insn_attr` bit 3) is set while media enable (`psw_bits` bit 3) is clear. In every other case the code is zero, even for a privileged instruction in user mode.
- R7: Otherwise, if media enable is clear, the code is media-disabled (bit 3) exactly when the media attribute (`insn_attr` bit 4) or the media-trap attribute (`insn_attr` bit 5) is set. In every other case the code is zero.
- R8: Otherwise, the code is privileged-instruction (bit 4) exactly when the privileged attribute (`insn_attr` bit 6) is set and supervisor (`psw_bits` bit 4) is clear. In every other case the code is zero.
- R9: `excp_code` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An instruction is being evaluated this cycle |
| bundle_viol | input | 1 | The issue bundle broke a packing constraint |
| insn_attr | input | 7 | Attributes: 0 non-excepting, 1 conditional, 2 float, 3 float-register access, 4 media, 5 media-trap, 6 privileged |
| psw_bits | input | 5 | Status: 0 non-excepting mode, 1 conditional mode, 2 float enable, 3 media enable, 4 supervisor |
| excp_vld | output | 1 | Verdict strobe, one cycle after `issue_vld` |
| excp_code | output | 5 | One-hot verdict: 0 illegal, 1 not-implemented, 2 float-disabled, 3 media-disabled, 4 privileged; all zeros means none |

## Verification
A wrong branch selection shows at the ports on the very next cycle. It appears either as a code from a later check leaking through a disabled-unit gate, or as a lower-priority code winning over a higher one. A stale or stuck output register shows as a strobe or code that does not follow the previous cycle's inputs, and idle cycles inserted between issues expose it at once. The bench sweeps every combination of the thirteen decision inputs, so any mis-wired bit index or inverted enable is caught within one pass.

// File: rtl/issue_excp_pkg.sv
package issue_excp_pkg;
  // attribute vector layout
  localparam int ATTR_W    = 7;
  localparam int A_NONEXC  = 0;
  localparam int A_COND    = 1;
  localparam int A_FLOAT   = 2;
  localparam int A_FRACC   = 3;
  localparam int A_MEDIA   = 4;
  localparam int A_MTRAP   = 5;
  localparam int A_PRIV    = 6;

  // status word layout
  localparam int STAT_W    = 5;
  localparam int S_NEMODE  = 0;
  localparam int S_CMODE   = 1;
  localparam int S_FPEN    = 2;
  localparam int S_MDEN    = 3;
  localparam int S_SUPER   = 4;

  // one-hot verdict layout
  localparam int EXC_W     = 5;
  localparam int E_ILLEGAL = 0;
  localparam int E_UNIMPL  = 1;
  localparam int E_FPOFF   = 2;
  localparam int E_MDOFF   = 3;
  localparam int E_PRIV    = 4;

  typedef logic [EXC_W-1:0] exc_code_t;

  localparam exc_code_t EXC_NONE = '0;

  function automatic exc_code_t exc_onehot(input int idx);
    exc_code_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/issue_excp_chain.sv
module issue_excp_chain
  import issue_excp_pkg::*;
(
  input  logic              bundle_viol,
  input  logic [ATTR_W-1:0] insn_attr,
  input  logic [STAT_W-1:0] psw_bits,
  output exc_code_t         code,
  output logic              sel_early,
  output logic              sel_fp,
  output logic              sel_media,
  output logic              sel_priv
);
  // the three checks ahead of the unit gates
  logic hit_ne;
  logic hit_co;

  assign hit_ne    = insn_attr[A_NONEXC] & ~psw_bits[S_NEMODE];
  assign hit_co    = insn_attr[A_COND]   & ~psw_bits[S_CMODE];
  assign sel_early = bundle_viol | hit_ne | hit_co;

  // which gated branch the chain lands in
  assign sel_fp    = ~sel_early & ~psw_bits[S_FPEN];
  assign sel_media = ~sel_early &  psw_bits[S_FPEN] & ~psw_bits[S_MDEN];
  assign sel_priv  = ~sel_early &  psw_bits[S_FPEN] &  psw_bits[S_MDEN];

  function automatic exc_code_t resolve(
    input logic              viol,
    input logic [ATTR_W-1:0] a,
    input logic [STAT_W-1:0] s
  );
    exc_code_t r;
    r = EXC_NONE;
    if (viol)
      r = exc_onehot(E_ILLEGAL);
    else if (a[A_NONEXC] && !s[S_NEMODE])
      r = exc_onehot(E_UNIMPL);
    else if (a[A_COND] && !s[S_CMODE])
      r = exc_onehot(E_UNIMPL);
    else if (!s[S_FPEN]) begin
      if (a[A_FLOAT] || (a[A_FRACC] && !s[S_MDEN]))
        r = exc_onehot(E_FPOFF);
    end
    else if (!s[S_MDEN]) begin
      if (a[A_MEDIA] || a[A_MTRAP])
        r = exc_onehot(E_MDOFF);
    end
    else if (a[A_PRIV] && !s[S_SUPER])
      r = exc_onehot(E_PRIV);
    return r;
  endfunction

  assign code = resolve(bundle_viol, insn_attr, psw_bits);
endmodule

// File: rtl/issue_excp_stage.sv
module issue_excp_stage
  import issue_excp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_vld,
  input  exc_code_t in_code,
  output logic      out_vld,
  output exc_code_t out_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_code <= EXC_NONE;
    end else begin
      out_vld  <= in_vld;
      out_code <= in_vld ? in_code : EXC_NONE;
    end
  end

  // R2: strobe tracks the previous issue cycle
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  a_r2_vld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  // R2: no code without a strobe
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> out_code == EXC_NONE);
endmodule

// File: rtl/issue_excp_prio.sv
module issue_excp_prio
  import issue_excp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_vld,
  input  logic              bundle_viol,
  input  logic [ATTR_W-1:0] insn_attr,
  input  logic [STAT_W-1:0] psw_bits,
  output logic              excp_vld,
  output logic [EXC_W-1:0]  excp_code
);
  exc_code_t code_nxt;
  exc_code_t code_q;
  logic      sel_early;
  logic      sel_fp;
  logic      sel_media;
  logic      sel_priv;

  issue_excp_chain u_chain (
    .bundle_viol (bundle_viol),
    .insn_attr   (insn_attr),
    .psw_bits    (psw_bits),
    .code        (code_nxt),
    .sel_early   (sel_early),
    .sel_fp      (sel_fp),
    .sel_media   (sel_media),
    .sel_priv    (sel_priv)
  );

  issue_excp_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (issue_vld),
    .in_code  (code_nxt),
    .out_vld  (excp_vld),
    .out_code (code_q)
  );

  assign excp_code = code_q;

  // R9: a single verdict at most
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(excp_code));
  // branch selectors are mutually exclusive
  a_r9_one_branch: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_early, sel_fp, sel_media, sel_priv}) == 1);
  // R3: a bundle violation always wins
  a_r3_viol_wins: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && bundle_viol |=> excp_code == exc_onehot(E_ILLEGAL));
  // R6: the float gate blocks every later check
  a_r6_fp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && sel_fp |=> !excp_code[E_MDOFF] && !excp_code[E_PRIV]
                            && !excp_code[E_UNIMPL] && !excp_code[E_ILLEGAL]);
  // R7: the media gate blocks the privilege check
  a_r7_media_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && sel_media |=> !excp_code[E_PRIV] && !excp_code[E_FPOFF]);
  // R8: a supervisor never sees a privilege fault
  a_r8_super_clean: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && psw_bits[S_SUPER] |=> !excp_code[E_PRIV]);
endmodule

// File: tb/issue_excp_prio_bench.sv
module issue_excp_prio_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       issue_vld;
  logic       bundle_viol;
  logic [6:0] insn_attr;
  logic [4:0] psw_bits;
  logic       excp_vld;
  logic [4:0] excp_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_excp_prio u_issue_excp_prio (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_vld   (issue_vld),
    .bundle_viol (bundle_viol),
    .insn_attr   (insn_attr),
    .psw_bits    (psw_bits),
    .excp_vld    (excp_vld),
    .excp_code   (excp_code)
  );

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got vld/code=%b expected %b", req, got, exp);
    end
  endtask

  // expected verdict written as independent sum-of-products per bit
  function automatic logic [4:0] model(input logic [12:0] v);
    logic vi, ne, co, fl, fra, me, mt, pr, nem, cm, ef, em, su, gate;
    logic [4:0] e;
    vi = v[0];  ne = v[1];  co = v[2];  fl = v[3];  fra = v[4];
    me = v[5];  mt = v[6];  pr = v[7];
    nem = v[8]; cm = v[9];  ef = v[10]; em = v[11]; su = v[12];
    gate = !vi && !(ne && !nem) && !(co && !cm);
    e[0] = vi;
    e[1] = !vi && ((ne && !nem) || (co && !cm));
    e[2] = gate && !ef && (fl || (fra && !em));
    e[3] = gate && ef && !em && (me || mt);
    e[4] = gate && ef && em && pr && !su;
    return e;
  endfunction

  function automatic string tag_of(input logic [12:0] v);
    if (v[0]) return "R3";
    if (v[1] && !v[8]) return "R4";
    if (v[2] && !v[9]) return "R5";
    if (!v[10]) return "R6";
    if (!v[11]) return "R7";
    return "R8";
  endfunction

  initial begin
    rst_n = 1'b0; issue_vld = 1'b1; bundle_viol = 1'b1;
    insn_attr = '1; psw_bits = '0;
    repeat (3) @(posedge clk);
    #1 check("R1", {excp_vld, excp_code}, 6'b0);
    @(negedge clk) rst_n = 1'b1; issue_vld = 1'b0;
    @(posedge clk); #1 check("R1", {excp_vld, excp_code}, 6'b0);

    for (int i = 0; i < 8192; i++) begin
      logic [12:0] v;
      logic        iv;
      logic [4:0]  exp;
      v  = 13'(i);
      iv = (i % 7) != 3;
      @(negedge clk);
      issue_vld   = iv;
      bundle_viol = v[0];
      insn_attr   = v[7:1];
      psw_bits    = v[12:8];
      @(posedge clk); #1;
      exp = iv ? model(v) : 5'b0;
      if (iv) check(tag_of(v), {excp_vld, excp_code}, {1'b1, exp});
      else    check("R2", {excp_vld, excp_code}, 6'b0);
      check("R9", {5'b0, ($countones(excp_code) > 1)}, 6'b0);
    end

    // back-to-back then idle: strobe must drop in the very next cycle
    @(negedge clk) issue_vld = 1'b1; bundle_viol = 1'b1;
    @(negedge clk) issue_vld = 1'b0;
    #1 check("R2", {excp_vld, excp_code}, 6'b100001);
    @(posedge clk); #1 check("R2", {excp_vld, excp_code}, 6'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule